// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible register layer of a sixteen-channel, descriptor-driven DMA controller. It sits behind a simple APB-style slave port and turns word accesses into reads and writes of per-channel register windows and of a small global area. For each channel it keeps the control/status word, the address of the first control block and a scratch debug word. It also shows the engine's working copy of the current descriptor (transfer info, source, destination, length, stride and next-block pointer) as read-only registers.

The transfer engine lives outside this block. It takes each channel's control-block address and a one-cycle start pulse, which is raised when software turns a channel's ACTIVE bit from 0 to 1 and the channel is enabled. The engine reports completion through per-channel set-END and set-INT strobes. Interrupt flags drive one interrupt line per channel and are collected in a global status word. A main 4 KiB window reaches channels 0 to 14 and the global registers. A second, 256-byte window reaches the last channel with the same register layout.

Top module: `dmac_csr_front`

## Requirements
- R1: Reset state: every channel enable bit is 1 (offset 0xFF0 reads 0x0000FFFF), every channel's status word, block address and debug word read 0, global status reads 0, and no interrupt line or start pulse is active.
- R2: In the main window, an offset below 0xF00 selects channel paddr[11:8] and register paddr[7:0]. Through the second window (psel_hi), paddr[7:0] selects a register of the last channel. Register offsets: 0x00 status, 0x04 block address, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C next block, 0x20 debug.
- R3: Only status, block address and debug are writable. Offsets 0x08 to 0x1C read the engine's descriptor inputs for that channel, and writes to them change nothing.
- R4: An access whose paddr[1:0] is not 0, or whose offset matches no register, reads 0, and a write to it changes no register.
- R5: A status write with bit 31 set first clears the channel's status word and block address. Bit 30 (abort) has no effect of its own.
- R6: A status write with bit 1 set clears END (bit 1). A status write with bit 2 set clears INT (bit 2), clears the channel's bit in the global status word and drops the channel's interrupt line.
- R7: After the clear actions, status bits in mask 0x30FF0001 take the written value and all other status bits keep their state.
- R8: When a status write takes ACTIVE (bit 0) from 0 to 1 and the channel's enable bit is 1, start_pulse for that channel is high for exactly the one cycle after the write edge. No pulse is raised otherwise.
- R9: An engine set-END or set-INT strobe sets status bit 1 or bit 2 at the next edge. Set-INT also sets the global status bit and the interrupt line. A software clear in the same cycle wins over the set.
- R10: Global status (0xFE0) is read-only: bit c is channel c's interrupt flag and writes are ignored. Global enable (0xFF0) stores bits 15:0 of a write, and these bits drive chan_enable.
- R11: A channel reset through status bit 31 leaves the global status bit and the interrupt line of that channel unchanged.
- R12: pready is always 1, so every access completes in its first access-phase cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel_main | input | 1 | Select for the 4 KiB main window |
| psel_hi | input | 1 | Select for the last channel's 256-byte window |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the selected window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Always 1 |
| eng_info | input | 16*32 | Per-channel current transfer info from the engine |
| eng_src | input | 16*32 | Per-channel current source address |
| eng_dst | input | 16*32 | Per-channel current destination address |
| eng_len | input | 16*32 | Per-channel remaining length |
| eng_stride | input | 16*32 | Per-channel stride word |
| eng_next | input | 16*32 | Per-channel next control-block pointer |
| eng_set_end | input | 16 | Per-channel strobe that sets END |
| eng_set_int | input | 16 | Per-channel strobe that sets INT and the interrupt |
| start_pulse | output | 16 | Per-channel one-cycle start request to the engine |
| chan_irq | output | 16 | Per-channel interrupt line |
| chan_enable | output | 16 | Global per-channel enable bits |
| chan_cb_addr | output | 16*32 | Per-channel control-block address register |

## Verification
Read data is combinational during the access phase, so the bench samples prdata 1 ns after it raises penable, in the same cycle. A write takes effect on the edge that ends its access phase. The start pulse, the interrupt lines and the enable outputs are registered, so the bench checks them at the falling edge right after that write edge. It then checks the pulse once more one cycle later to confirm it has gone. Engine strobes are held for exactly one rising edge, and their effect is checked at the next falling edge. In the set-and-clear race, the set strobe is held across the write edge itself.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned WIN_AW    = 12;
    localparam int unsigned MAX_CH    = 16;

    // control/status word layout
    localparam int unsigned ST_ACTIVE = 0;
    localparam int unsigned ST_END    = 1;
    localparam int unsigned ST_INT    = 2;
    localparam int unsigned ST_CLEAR  = 31;
    localparam logic [DATA_W-1:0] ST_RW_MASK = 32'h30FF_0001;

    // main-window map
    localparam logic [WIN_AW-1:0] CHAN_AREA_END = 12'hF00;
    localparam logic [WIN_AW-1:0] OFS_IRQ_STAT  = 12'hFE0;
    localparam logic [WIN_AW-1:0] OFS_CH_ENABLE = 12'hFF0;

    typedef enum logic [3:0] {
        RK_STATUS,
        RK_CBADDR,
        RK_INFO,
        RK_SRC,
        RK_DST,
        RK_LEN,
        RK_STRIDE,
        RK_NEXT,
        RK_DEBUG,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] info;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] stride;
        logic [DATA_W-1:0] next;
    } desc_view_t;

    typedef struct packed {
        logic status;
        logic cbaddr;
        logic debug;
    } chan_wr_t;

    function automatic reg_kind_e kind_of(input logic [7:0] ofs);
        reg_kind_e k;
        case (ofs)
            8'h00:   k = RK_STATUS;
            8'h04:   k = RK_CBADDR;
            8'h08:   k = RK_INFO;
            8'h0C:   k = RK_SRC;
            8'h10:   k = RK_DST;
            8'h14:   k = RK_LEN;
            8'h18:   k = RK_STRIDE;
            8'h1C:   k = RK_NEXT;
            8'h20:   k = RK_DEBUG;
            default: k = RK_NONE;
        endcase
        return k;
    endfunction

    // status-word update for a software write: channel clear, then the
    // write-one-to-clear flags, then the masked read-write field
    function automatic logic [DATA_W-1:0] status_after_write(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wval
    );
        logic [DATA_W-1:0] nxt;
        nxt = cur;
        if (wval[ST_CLEAR]) nxt = '0;
        if (wval[ST_END])   nxt[ST_END] = 1'b0;
        if (wval[ST_INT])   nxt[ST_INT] = 1'b0;
        nxt = (nxt & ~ST_RW_MASK) | (wval & ST_RW_MASK);
        return nxt;
    endfunction

endpackage

// File: rtl/dmac_csr_decode.sv
module dmac_csr_decode
    import dmac_csr_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              psel_main,
    input  logic              psel_hi,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [WIN_AW-1:0] paddr,
    output logic              wr_en,
    output logic              chan_hit,
    output logic [CH_W-1:0]   chan_idx,
    output reg_kind_e         kind,
    output logic              stat_hit,
    output logic              en_hit
);

    logic aligned;

    always_comb begin
        aligned  = (paddr[1:0] == 2'b00);
        wr_en    = (psel_main | psel_hi) & penable & pwrite;
        chan_hit = 1'b0;
        chan_idx = '0;
        kind     = RK_NONE;
        stat_hit = 1'b0;
        en_hit   = 1'b0;
        if (psel_main && aligned) begin
            if (paddr < CHAN_AREA_END) begin
                chan_idx = paddr[8 +: CH_W];
                chan_hit = (int'(paddr[11:8]) < int'(NUM_CH));
                kind     = kind_of(paddr[7:0]);
            end else begin
                stat_hit = (paddr == OFS_IRQ_STAT);
                en_hit   = (paddr == OFS_CH_ENABLE);
            end
        end else if (psel_hi && aligned) begin
            chan_hit = 1'b1;
            chan_idx = CH_W'(NUM_CH - 1);
            kind     = kind_of(paddr[7:0]);
        end
    end

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_end,
    input  logic              set_int,
    input  logic              chan_en,
    input  reg_kind_e         rd_kind,
    input  desc_view_t        desc,
    output logic [DATA_W-1:0] rdata,
    output logic              start,
    output logic              irq,
    output logic [DATA_W-1:0] cb_addr
);

    logic [DATA_W-1:0] status_q, status_set, status_d;
    logic [DATA_W-1:0] cb_q, cb_d;
    logic [DATA_W-1:0] dbg_q, dbg_d;
    logic              irq_q, irq_d;
    logic              start_q, start_d;

    always_comb begin
        // engine flags land first, so a software clear in the same cycle wins
        status_set = status_q;
        if (set_end) status_set[ST_END] = 1'b1;
        if (set_int) status_set[ST_INT] = 1'b1;
        status_d = wr.status ? status_after_write(status_set, wdata) : status_set;

        irq_d = irq_q | set_int;
        if (wr.status && wdata[ST_INT]) irq_d = 1'b0;

        start_d = wr.status & ~status_q[ST_ACTIVE] & status_d[ST_ACTIVE] & chan_en;

        cb_d = cb_q;
        if (wr.cbaddr) cb_d = wdata;
        if (wr.status && wdata[ST_CLEAR]) cb_d = '0;

        dbg_d = wr.debug ? wdata : dbg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            cb_q     <= '0;
            dbg_q    <= '0;
            irq_q    <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            status_q <= status_d;
            cb_q     <= cb_d;
            dbg_q    <= dbg_d;
            irq_q    <= irq_d;
            start_q  <= start_d;
        end
    end

    always_comb begin
        case (rd_kind)
            RK_STATUS: rdata = status_q;
            RK_CBADDR: rdata = cb_q;
            RK_INFO:   rdata = desc.info;
            RK_SRC:    rdata = desc.src;
            RK_DST:    rdata = desc.dst;
            RK_LEN:    rdata = desc.len;
            RK_STRIDE: rdata = desc.stride;
            RK_NEXT:   rdata = desc.next;
            RK_DEBUG:  rdata = dbg_q;
            default:   rdata = '0;
        endcase
    end

    assign start   = start_q;
    assign irq     = irq_q;
    assign cb_addr = cb_q;

endmodule

// File: rtl/dmac_glob_regs.sv
module dmac_glob_regs
    import dmac_csr_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_enable,
    input  logic [NUM_CH-1:0] wdata,
    input  logic              rd_stat,
    input  logic              rd_enable,
    input  logic [NUM_CH-1:0] irq_vec,
    output logic [NUM_CH-1:0] enable,
    output logic [DATA_W-1:0] rdata
);

    logic [NUM_CH-1:0] enable_q;

    always_ff @(posedge clk) begin
        if (rst)            enable_q <= '1;
        else if (wr_enable) enable_q <= wdata;
    end

    always_comb begin
        if (rd_stat)        rdata = DATA_W'(irq_vec);
        else if (rd_enable) rdata = DATA_W'(enable_q);
        else                rdata = '0;
    end

    assign enable = enable_q;

endmodule

// File: rtl/dmac_csr_front.sv
module dmac_csr_front
    import dmac_csr_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned VEC_W = NUM_CH * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel_main,
    input  logic              psel_hi,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [WIN_AW-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic [VEC_W-1:0]  eng_info,
    input  logic [VEC_W-1:0]  eng_src,
    input  logic [VEC_W-1:0]  eng_dst,
    input  logic [VEC_W-1:0]  eng_len,
    input  logic [VEC_W-1:0]  eng_stride,
    input  logic [VEC_W-1:0]  eng_next,
    input  logic [NUM_CH-1:0] eng_set_end,
    input  logic [NUM_CH-1:0] eng_set_int,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] chan_irq,
    output logic [NUM_CH-1:0] chan_enable,
    output logic [VEC_W-1:0]  chan_cb_addr
);

    logic              wr_en, chan_hit, stat_hit, en_hit;
    logic [CH_W-1:0]   chan_idx;
    reg_kind_e         kind;
    logic [DATA_W-1:0] glob_rdata;
    logic [DATA_W-1:0] chan_rdata [NUM_CH];

    dmac_csr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .psel_main (psel_main),
        .psel_hi   (psel_hi),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .wr_en     (wr_en),
        .chan_hit  (chan_hit),
        .chan_idx  (chan_idx),
        .kind      (kind),
        .stat_hit  (stat_hit),
        .en_hit    (en_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic       sel;
        chan_wr_t   wr;
        desc_view_t desc;

        assign sel       = wr_en & chan_hit & (chan_idx == CH_W'(c));
        assign wr.status = sel & (kind == RK_STATUS);
        assign wr.cbaddr = sel & (kind == RK_CBADDR);
        assign wr.debug  = sel & (kind == RK_DEBUG);

        assign desc.info   = eng_info  [c*DATA_W +: DATA_W];
        assign desc.src    = eng_src   [c*DATA_W +: DATA_W];
        assign desc.dst    = eng_dst   [c*DATA_W +: DATA_W];
        assign desc.len    = eng_len   [c*DATA_W +: DATA_W];
        assign desc.stride = eng_stride[c*DATA_W +: DATA_W];
        assign desc.next   = eng_next  [c*DATA_W +: DATA_W];

        dmac_chan_regs u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr),
            .wdata   (pwdata),
            .set_end (eng_set_end[c]),
            .set_int (eng_set_int[c]),
            .chan_en (chan_enable[c]),
            .rd_kind (kind),
            .desc    (desc),
            .rdata   (chan_rdata[c]),
            .start   (start_pulse[c]),
            .irq     (chan_irq[c]),
            .cb_addr (chan_cb_addr[c*DATA_W +: DATA_W])
        );
    end

    dmac_glob_regs #(.NUM_CH(NUM_CH)) u_glob (
        .clk       (clk),
        .rst       (rst),
        .wr_enable (wr_en & en_hit),
        .wdata     (pwdata[NUM_CH-1:0]),
        .rd_stat   (stat_hit),
        .rd_enable (en_hit),
        .irq_vec   (chan_irq),
        .enable    (chan_enable),
        .rdata     (glob_rdata)
    );

    assign prdata = chan_hit ? chan_rdata[chan_idx] : glob_rdata;
    assign pready = 1'b1;

endmodule

// File: rtl/dmac_csr_front_chk.sv
module dmac_csr_front_chk #(
    parameter int unsigned NUM_CH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              psel_main,
    input logic              psel_hi,
    input logic              penable,
    input logic              pwrite,
    input logic [31:0]       pwdata,
    input logic              pready,
    input logic [NUM_CH-1:0] eng_set_int,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] chan_irq,
    input logic [NUM_CH-1:0] chan_enable
);

    logic wr_any;
    assign wr_any = (psel_main | psel_hi) & penable & pwrite;

    assert_enable_reset_R1: assert property (@(posedge clk)
        rst |=> (chan_enable == '1));

    assert_irq_reset_R1: assert property (@(posedge clk)
        rst |=> (chan_irq == '0) && (start_pulse == '0));

    assert_start_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_pulse));

    assert_start_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        (|start_pulse) |-> $past(wr_any));

    assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (start_pulse & ~$past(chan_enable)) == '0);

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (chan_irq & ~$past(chan_irq) & ~$past(eng_set_int)) == '0);

    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (|(~chan_irq & $past(chan_irq))) |-> $past(wr_any && pwdata[2]));

    assert_pready_R12: assert property (@(posedge clk) disable iff (rst)
        pready);

endmodule

bind dmac_csr_front dmac_csr_front_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .psel_main   (psel_main),
    .psel_hi     (psel_hi),
    .penable     (penable),
    .pwrite      (pwrite),
    .pwdata      (pwdata),
    .pready      (pready),
    .eng_set_int (eng_set_int),
    .start_pulse (start_pulse),
    .chan_irq    (chan_irq),
    .chan_enable (chan_enable)
);

// File: tb/dmac_csr_front_tb.sv
module dmac_csr_front_tb;

    localparam int NCH        = 16;
    localparam int CLK_PERIOD = 10;
    localparam int VW         = NCH * 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            psel_main, psel_hi, penable, pwrite;
    logic [11:0]     paddr;
    logic [31:0]     pwdata, prdata;
    logic            pready;
    logic [VW-1:0]   eng_info, eng_src, eng_dst, eng_len, eng_stride, eng_next;
    logic [NCH-1:0]  eng_set_end, eng_set_int;
    logic [NCH-1:0]  start_pulse, chan_irq, chan_enable;
    logic [VW-1:0]   chan_cb_addr;

    int n_checks = 0;
    int n_errs   = 0;

    dmac_csr_front #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst(rst),
        .psel_main(psel_main), .psel_hi(psel_hi), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready),
        .eng_info(eng_info), .eng_src(eng_src), .eng_dst(eng_dst),
        .eng_len(eng_len), .eng_stride(eng_stride), .eng_next(eng_next),
        .eng_set_end(eng_set_end), .eng_set_int(eng_set_int),
        .start_pulse(start_pulse), .chan_irq(chan_irq),
        .chan_enable(chan_enable), .chan_cb_addr(chan_cb_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] eng_val(input int c, input int k);
        return 32'hD000_0000 | (32'(k) << 20) | (32'(c) << 8) | 32'((c * 7 + k) & 8'hFF);
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic hi, input logic wr, input logic [11:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        psel_main = ~hi; psel_hi = hi; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 rd = prdata;
        @(negedge clk);
        psel_main = 1'b0; psel_hi = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr_main(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b0, 1'b1, a, d, dummy);
    endtask

    task automatic rd_main(input logic [11:0] a, output logic [31:0] d);
        xfer(1'b0, 1'b0, a, 32'h0, d);
    endtask

    // channel NCH-1 goes through the second window, the rest through the main one
    task automatic wr_ch(input int c, input logic [7:0] ofs, input logic [31:0] d);
        logic [31:0] dummy;
        if (c == NCH - 1) xfer(1'b1, 1'b1, {4'h0, ofs}, d, dummy);
        else              xfer(1'b0, 1'b1, {4'(c), ofs}, d, dummy);
    endtask

    task automatic rd_ch(input int c, input logic [7:0] ofs, output logic [31:0] d);
        if (c == NCH - 1) xfer(1'b1, 1'b0, {4'h0, ofs}, 32'h0, d);
        else              xfer(1'b0, 1'b0, {4'(c), ofs}, 32'h0, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] v;
        psel_main = 0; psel_hi = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        eng_set_end = '0; eng_set_int = '0;
        for (int c = 0; c < NCH; c++) begin
            eng_info  [c*32 +: 32] = eng_val(c, 0);
            eng_src   [c*32 +: 32] = eng_val(c, 1);
            eng_dst   [c*32 +: 32] = eng_val(c, 2);
            eng_len   [c*32 +: 32] = eng_val(c, 3);
            eng_stride[c*32 +: 32] = eng_val(c, 4);
            eng_next  [c*32 +: 32] = eng_val(c, 5);
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 enable port", 32'(chan_enable), 32'h0000_FFFF);
        check("R1 irq lines", 32'(chan_irq), 32'h0);
        check("R1 start lines", 32'(start_pulse), 32'h0);
        check("R12 pready", 32'(pready), 32'h1);
        rd_main(12'hFF0, v); check("R1 enable reg", v, 32'h0000_FFFF);
        rd_main(12'hFE0, v); check("R1 status reg", v, 32'h0);

        // R2/R3 sweep of all channels and registers
        for (int c = 0; c < NCH; c++) begin
            rd_ch(c, 8'h00, v); check("R1 status word", v, 32'h0);
            rd_ch(c, 8'h04, v); check("R1 block addr", v, 32'h0);
            wr_ch(c, 8'h04, 32'hC000_0000 | (32'(c) << 4));
            wr_ch(c, 8'h20, ~(32'hC000_0000 | (32'(c) << 4)));
            wr_ch(c, 8'h08, 32'hFFFF_FFFF);
            wr_ch(c, 8'h14, 32'h0);
            rd_ch(c, 8'h04, v); check("R2 block addr", v, 32'hC000_0000 | (32'(c) << 4));
            check("R2 cb port", chan_cb_addr[c*32 +: 32], 32'hC000_0000 | (32'(c) << 4));
            for (int k = 0; k < 6; k++) begin
                rd_ch(c, 8'(8 + 4 * k), v);
                check("R3 descriptor view", v, eng_val(c, k));
            end
            rd_ch(c, 8'h20, v); check("R2 debug", v, ~(32'hC000_0000 | (32'(c) << 4)));
            rd_ch(c, 8'h00, v); check("R3 status untouched", v, 32'h0);
        end

        // R4 unknown and misaligned offsets
        rd_main(12'h024, v); check("R4 unknown chan ofs", v, 32'h0);
        rd_main(12'h3FC, v); check("R4 unknown chan ofs", v, 32'h0);
        rd_main(12'hF00, v); check("R4 unknown global", v, 32'h0);
        rd_main(12'hFF4, v); check("R4 unknown global", v, 32'h0);
        rd_main(12'h205, v); check("R4 misaligned read", v, 32'h0);
        wr_main(12'h206, 32'h1111_2222);
        rd_main(12'h204, v); check("R4 misaligned write", v, 32'hC000_0020);
        wr_main(12'hFF2, 32'h0);
        check("R4 misaligned enable", 32'(chan_enable), 32'h0000_FFFF);

        // R7 masked update, R5 abort has no effect
        wr_ch(1, 8'h00, 32'h7FFF_FFF8);
        check("R8 no start when ACTIVE stays 0", 32'(start_pulse), 32'h0);
        rd_ch(1, 8'h00, v); check("R7 masked field", v, 32'h30FF_0000);
        @(negedge clk); eng_set_end[1] = 1'b1;
        @(negedge clk); eng_set_end[1] = 1'b0;
        rd_ch(1, 8'h00, v); check("R9 end set", v, 32'h30FF_0002);
        wr_ch(1, 8'h00, 32'h0001_0000);
        rd_ch(1, 8'h00, v); check("R7 keep non-mask", v, 32'h0001_0002);
        wr_ch(1, 8'h00, 32'h0000_0002);
        rd_ch(1, 8'h00, v); check("R6 end clear", v, 32'h0);

        // R8 start pulse
        wr_ch(3, 8'h00, 32'h1);
        check("R8 start pulse", 32'(start_pulse), 32'h0000_0008);
        @(negedge clk);
        check("R8 pulse one cycle", 32'(start_pulse), 32'h0);
        wr_ch(3, 8'h00, 32'h1);
        check("R8 no restart", 32'(start_pulse), 32'h0);
        wr_ch(NCH - 1, 8'h00, 32'h1);
        check("R8 start last chan", 32'(start_pulse), 32'h0000_8000);
        wr_ch(7, 8'h00, 32'h4000_0001);
        check("R5 abort ignored start", 32'(start_pulse), 32'h0000_0080);
        rd_ch(7, 8'h00, v); check("R5 abort ignored", v, 32'h1);
        wr_main(12'hFF0, 32'h0000_FFDF);
        check("R10 enable port", 32'(chan_enable), 32'h0000_FFDF);
        wr_ch(5, 8'h00, 32'h1);
        check("R8 disabled no start", 32'(start_pulse), 32'h0);
        rd_ch(5, 8'h00, v); check("R8 active still set", v, 32'h1);
        wr_main(12'hFF0, 32'hFFFF_0000);
        rd_main(12'hFF0, v); check("R10 enable low bits", v, 32'h0);
        wr_main(12'hFF0, 32'h1234_A5A5);
        rd_main(12'hFF0, v); check("R10 enable pattern", v, 32'h0000_A5A5);
        wr_main(12'hFF0, 32'h0000_FFFF);

        // R9/R6 engine flags and software clear
        @(negedge clk); eng_set_end[2] = 1'b1; eng_set_int[2] = 1'b1;
        @(negedge clk); eng_set_end[2] = 1'b0; eng_set_int[2] = 1'b0;
        check("R9 irq raised", 32'(chan_irq), 32'h0000_0004);
        rd_ch(2, 8'h00, v); check("R9 end+int", v, 32'h6);
        rd_main(12'hFE0, v); check("R9 status bit", v, 32'h0000_0004);
        wr_ch(2, 8'h00, 32'h2);
        rd_ch(2, 8'h00, v); check("R6 end cleared only", v, 32'h4);
        check("R6 irq held", 32'(chan_irq), 32'h0000_0004);
        wr_ch(2, 8'h00, 32'h4);
        check("R6 irq dropped", 32'(chan_irq), 32'h0);
        rd_ch(2, 8'h00, v); check("R6 int cleared", v, 32'h0);
        rd_main(12'hFE0, v); check("R6 status cleared", v, 32'h0);

        // R9 simultaneous set and clear: clear wins
        eng_set_int[4] = 1'b1;
        wr_ch(4, 8'h00, 32'h4);
        eng_set_int[4] = 1'b0;
        check("R9 clear wins irq", 32'(chan_irq), 32'h0);
        rd_ch(4, 8'h00, v); check("R9 clear wins flag", v, 32'h0);

        // R5/R11 channel clear
        @(negedge clk); eng_set_int[6] = 1'b1;
        @(negedge clk); eng_set_int[6] = 1'b0;
        wr_ch(6, 8'h00, 32'h00FF_0001);
        check("R8 start ch6", 32'(start_pulse), 32'h0000_0040);
        rd_ch(6, 8'h00, v); check("R7 ch6 status", v, 32'h00FF_0005);
        wr_ch(6, 8'h00, 32'h8000_0000);
        rd_ch(6, 8'h00, v); check("R5 status cleared", v, 32'h0);
        rd_ch(6, 8'h04, v); check("R5 block addr cleared", v, 32'h0);
        rd_ch(6, 8'h20, v); check("R5 debug kept", v, ~32'hC000_0060);
        check("R11 irq kept", 32'(chan_irq), 32'h0000_0040);
        rd_main(12'hFE0, v); check("R11 status kept", v, 32'h0000_0040);
        wr_main(12'hFE0, 32'h0);
        rd_main(12'hFE0, v); check("R10 status read-only", v, 32'h0000_0040);
        wr_ch(6, 8'h00, 32'h4);
        check("R6 irq6 dropped", 32'(chan_irq), 32'h0);
        check("R12 pready", 32'(pready), 32'h1);

        report();
        $finish;
    end

endmodule